// File: doc/BRIEF.md
# SPI Master with Register Bank

This block is a single-device SPI master that a host processor controls through five 32-bit registers at word-aligned byte offsets. Software picks a word size (8 or 16 bits) and a clock prescale value, drives the device select through a control bit, and writes a word to the transmit register. The block then shifts that word out on `spiMosi` while it shifts a word in from `spiMiso`. When the word is done it sets a completion flag that software polls.

The serial clock is the system clock divided by an even ratio between 4 and 30. Only SPI mode 0 is produced: the clock idles low, both sides sample on the rising edge, and data changes on the falling edge. Words go out most significant bit first. A typical word exchange works like this: software clears the completion flag, writes the transmit register, polls the flag until it reads nonzero, then reads the receive register.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset `spiCsN` is 1 and `spiSclk` is 0. The control (0x00), configuration (0x04), transmit (0x08), receive (0x0C) and completion (0x10) registers all read 0.
- R2: Bit 0 of the control register sets the device select. Writing 1 drives `spiCsN` low and writing 0 drives it high. Bit 0 reads back the last value written.
- R3: The configuration register keeps bits [5:0] and reads them back, with zeros above. Bit 5 = 1 selects 16-bit words and bit 5 = 0 selects 8-bit words. Bits [4:0] are the prescale value.
- R4: A prescale value with bit 4 set and a low nibble h from 2 to 15 gives a serial clock that is high for h system cycles and low for h system cycles, so the ratio is 2h. Any other prescale value acts as h = 2.
- R5: Mode 0 timing. `spiSclk` is low whenever no word is in flight. `spiMosi` does not change while `spiSclk` is high. `spiMiso` is sampled at each rising edge.
- R6: A write to the transmit register while the block is idle starts exactly one word of 8 or 16 clock pulses, sent MSB first. In 8-bit mode only bits [7:0] of the written value are sent.
- R7: After the last falling edge of a word, the completion register reads 1 and the busy bit clears.
- R8: A write to the completion register with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it unchanged.
- R9: The receive register holds the word just received, with the first bit received at the word's MSB. In 8-bit mode the word sits in bits [7:0], and all bits above the word are 0.
- R10: Bit 1 of the control register reads 1 while a word is in flight. A transmit write during that time is ignored: neither the transmit register nor the bits being sent change.
- R11: The transmit register reads back bits [15:0] of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register byte offset |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |
| spiCsN | output | 1 | Device select, active low |

## Verification
Errors in the phase counter show up at the ports within the first bit. The number of system cycles that `spiSclk` stays high per word (bits times h) moves, and the completion flag comes early or late. A bit counter that is off by one changes the count of rising edges and slides the received byte, so the receive register read right after completion shows the error at once. Errors in the busy and ignore logic show in the same word: the control register read back mid-word, or the transmit readback after a rejected write, gives the wrong value.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int PRE_W   = 5;
  localparam int CFG_W   = PRE_W + 1;
  localparam int HALF_W  = PRE_W - 1;
  localparam int BITC_W  = $clog2(WORD_W);
  localparam int MIN_HALF = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h10;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadWord;
    logic riseEdge;
    logic fallEdge;
    logic lastFall;
    logic word16;
  } shiftCmd_t;

  // prescale field to half-period length in system cycles
  function automatic logic [HALF_W-1:0] halfFromPrescale(input logic [PRE_W-1:0] pre);
    if (!pre[PRE_W-1] || pre[HALF_W-1:0] < HALF_W'(MIN_HALF))
      return HALF_W'(MIN_HALF);
    return pre[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cfgWide,
  input  logic [PRE_W-1:0] cfgPrescale,
  output logic             busy,
  output shiftCmd_t        cmd
);
  logic [HALF_W-1:0] halfLat;
  logic [HALF_W-1:0] phaseCnt;
  logic [BITC_W-1:0] bitsLeft;
  logic              phaseHigh;
  logic              wideLat;
  logic              goNow;
  logic              phaseEnd;
  logic [HALF_W-1:0] halfNew;

  assign goNow    = startReq && !busy;
  assign phaseEnd = busy && (phaseCnt == '0);
  assign halfNew  = halfFromPrescale(cfgPrescale);

  always_comb begin
    cmd.loadWord = goNow;
    cmd.riseEdge = phaseEnd && !phaseHigh;
    cmd.fallEdge = phaseEnd && phaseHigh;
    cmd.lastFall = phaseEnd && phaseHigh && (bitsLeft == '0);
    cmd.word16   = goNow ? cfgWide : wideLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      halfLat   <= HALF_W'(MIN_HALF);
      phaseCnt  <= '0;
      bitsLeft  <= '0;
      phaseHigh <= 1'b0;
      wideLat   <= 1'b0;
    end else if (goNow) begin
      busy      <= 1'b1;
      halfLat   <= halfNew;
      phaseCnt  <= halfNew - 1'b1;
      bitsLeft  <= cfgWide ? BITC_W'(WORD_W - 1) : BITC_W'(BYTE_W - 1);
      phaseHigh <= 1'b0;
      wideLat   <= cfgWide;
    end else if (busy) begin
      if (phaseCnt != '0) begin
        phaseCnt <= phaseCnt - 1'b1;
      end else begin
        phaseCnt  <= halfLat - 1'b1;
        phaseHigh <= !phaseHigh;
        if (phaseHigh) begin
          if (bitsLeft == '0) busy <= 1'b0;
          else                bitsLeft <= bitsLeft - 1'b1;
        end
      end
    end
  end

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfLat >= HALF_W'(MIN_HALF))); // R4
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lastFall |=> !busy); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy); // R6
endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic              busy,
  input  shiftCmd_t         cmd,
  output logic              startReq,
  output logic              cfgWide,
  output logic [PRE_W-1:0]  cfgPrescale,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiCsN
);
  logic              csOn;
  logic [CFG_W-1:0]  cfgReg;
  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxReg;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic              causeFlag;
  logic              sclkQ;
  logic              wrCtrl, wrCfg, wrTx, wrCause;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[BUS_W-1:WORD_W];

  assign wrCtrl  = regWrEn && (regAddr == OFS_CTRL);
  assign wrCfg   = regWrEn && (regAddr == OFS_CFG);
  assign wrTx    = regWrEn && (regAddr == OFS_TX);
  assign wrCause = regWrEn && (regAddr == OFS_CAUSE);

  assign startReq    = wrTx;
  assign cfgWide     = cfgReg[CFG_W-1];
  assign cfgPrescale = cfgReg[PRE_W-1:0];
  assign spiSclk     = sclkQ;
  assign spiMosi     = txShift[WORD_W-1];
  assign spiCsN      = !csOn;

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:  regRdata = {{(BUS_W-2){1'b0}}, busy, csOn};
      OFS_CFG:   regRdata = {{(BUS_W-CFG_W){1'b0}}, cfgReg};
      OFS_TX:    regRdata = {{(BUS_W-WORD_W){1'b0}}, txReg};
      OFS_RX:    regRdata = {{(BUS_W-WORD_W){1'b0}}, rxReg};
      OFS_CAUSE: regRdata = {{(BUS_W-1){1'b0}}, causeFlag};
      default:   regRdata = '0;
    endcase
  end

  // register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOn   <= 1'b0;
      cfgReg <= '0;
      txReg  <= '0;
    end else begin
      if (wrCtrl) csOn <= regWdata[0];
      if (wrCfg)  cfgReg <= regWdata[CFG_W-1:0];
      if (wrTx && !busy) txReg <= regWdata[WORD_W-1:0];
    end
  end

  // completion flag: set by the last falling edge, cleared by a zero write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         causeFlag <= 1'b0;
    else if (cmd.lastFall)             causeFlag <= 1'b1;
    else if (wrCause && !regWdata[0])  causeFlag <= 1'b0;
  end

  // shift engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxReg   <= '0;
      sclkQ   <= 1'b0;
    end else begin
      if (cmd.loadWord) begin
        txShift <= cmd.word16 ? regWdata[WORD_W-1:0]
                              : {regWdata[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
        rxShift <= '0;
        sclkQ   <= 1'b0;
      end else if (cmd.riseEdge) begin
        sclkQ   <= 1'b1;
        rxShift <= {rxShift[WORD_W-2:0], spiMiso};
      end else if (cmd.fallEdge) begin
        sclkQ   <= 1'b0;
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
      if (cmd.lastFall)
        rxReg <= cmd.word16 ? rxShift
                            : {{(WORD_W-BYTE_W){1'b0}}, rxShift[BYTE_W-1:0]};
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiSclk); // R5
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi)); // R5
  AST_CS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (spiCsN == !$past(regWdata[0]))); // R2
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrCause && !regWdata[0] && !cmd.lastFall) |=> !causeFlag); // R8
  AST_CAUSE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lastFall |=> causeFlag); // R7
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiCsN
);
  shiftCmd_t        cmd;
  logic             busy;
  logic             startReq;
  logic             cfgWide;
  logic [PRE_W-1:0] cfgPrescale;

  spi_host_ctl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .cfgWide     (cfgWide),
    .cfgPrescale (cfgPrescale),
    .busy        (busy),
    .cmd         (cmd)
  );

  spi_host_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .busy        (busy),
    .cmd         (cmd),
    .startReq    (startReq),
    .cfgWide     (cfgWide),
    .cfgPrescale (cfgPrescale),
    .spiSclk     (spiSclk),
    .spiMosi     (spiMosi),
    .spiMiso     (spiMiso),
    .spiCsN      (spiCsN)
  );
endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_CAUSE = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        spiSclk, spiMosi, spiMiso, spiCsN;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  int vectors = 0;
  int miscompares = 0;

  // device model: drives on falling edge, captures on rising edge
  logic [15:0] slaveOut = '0;
  logic [15:0] slaveIn  = '0;
  int hiCnt = 0;
  int riseCnt = 0;
  assign spiMiso = slaveOut[15];
  always @(negedge spiSclk) slaveOut <= {slaveOut[14:0], 1'b0};
  always @(posedge spiSclk) begin
    slaveIn <= {slaveIn[14:0], spiMosi};
    riseCnt++;
  end
  always @(negedge clk) if (spiSclk === 1'b1) hiCnt++;

  typedef struct {
    string       tag;
    logic [31:0] rx;
    logic [15:0] mosi;
    int          hi;
    int          rise;
  } item_t;
  item_t expQ[$];
  item_t obsQ[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // clear flag, prime the device model, push the expectation, write tx
  task automatic startWord(input string tag, input bit wide, input int half,
                           input logic [15:0] tx, input logic [15:0] devWord);
    item_t e;
    busWrite(A_CAUSE, 32'h0);
    slaveOut = wide ? devWord : {devWord[7:0], 8'h00};
    slaveIn  = '0;
    hiCnt    = 0;
    riseCnt  = 0;
    e.tag  = tag;
    e.rx   = wide ? {16'h0, devWord} : {24'h0, devWord[7:0]};
    e.mosi = wide ? tx : {8'h00, tx[7:0]};
    e.hi   = (wide ? 16 : 8) * half;
    e.rise = wide ? 16 : 8;
    expQ.push_back(e);
    busWrite(A_TX, {16'hDEAD, tx});
  endtask

  task automatic finishWord(input string tag, input bit wide);
    logic [31:0] v;
    item_t o;
    do busRead(A_CAUSE, v); while (v == 32'h0);
    busRead(A_RX, v);
    o.tag  = tag;
    o.rx   = v;
    o.mosi = wide ? slaveIn : {8'h00, slaveIn[7:0]};
    o.hi   = hiCnt;
    o.rise = riseCnt;
    obsQ.push_back(o);
  endtask

  task automatic runWord(input string tag, input bit wide, input int half,
                         input logic [15:0] tx, input logic [15:0] devWord);
    startWord(tag, wide, half, tx, devWord);
    finishWord(tag, wide);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t e, o;
      wait (obsQ.size() > 0);
      o = obsQ.pop_front();
      e = expQ.pop_front();
      check({o.tag, " R9 rx"}, o.rx, e.rx);
      check({o.tag, " R6 mosi"}, {16'h0, o.mosi}, {16'h0, e.mosi});
      check({o.tag, " R4 high cycles"}, o.hi, e.hi);
      check({o.tag, " R6 pulses"}, o.rise, e.rise);
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    check("R1 csN", {31'h0, spiCsN}, 32'h1);
    check("R1 sclk", {31'h0, spiSclk}, 32'h0);
    rstN = 1'b1;
    busRead(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
    busRead(A_CFG, v);   check("R1 cfg", v, 32'h0);
    busRead(A_TX, v);    check("R1 tx", v, 32'h0);
    busRead(A_RX, v);    check("R1 rx", v, 32'h0);
    busRead(A_CAUSE, v); check("R1 cause", v, 32'h0);

    busWrite(A_CTRL, 32'h1);
    #1 check("R2 csN low", {31'h0, spiCsN}, 32'h0);
    busRead(A_CTRL, v); check("R2 ctrl readback", v, 32'h1);

    busWrite(A_CFG, 32'hFFFF_FF15);
    busRead(A_CFG, v); check("R3 cfg readback", v, 32'h15);
    runWord("R6 8-bit div10", 1'b0, 5, 16'h12A5, 16'h003C);
    busRead(A_TX, v); check("R11 tx readback", v, 32'h12A5);
    busRead(A_CAUSE, v); check("R7 cause set", v, 32'h1);
    busRead(A_CTRL, v); check("R7 busy clear", v, 32'h1);

    busWrite(A_CFG, 32'h3F);
    runWord("R4 16-bit div30", 1'b1, 15, 16'hBEEF, 16'h1234);
    busWrite(A_CFG, 32'h20);
    runWord("R4 clamp zero prescale", 1'b1, 2, 16'h8001, 16'hC3A5);
    busWrite(A_CFG, 32'h11);
    runWord("R4 clamp low nibble", 1'b0, 2, 16'h0081, 16'h00E7);
    busWrite(A_CFG, 32'h12);
    runWord("R4 div4", 1'b0, 2, 16'h007E, 16'h0001);
    busWrite(A_CFG, 32'h1E);
    runWord("R5 8-bit div28", 1'b0, 14, 16'h0055, 16'h00AA);

    busWrite(A_CAUSE, 32'h1);
    busRead(A_CAUSE, v); check("R8 write one keeps", v, 32'h1);
    busWrite(A_CAUSE, 32'h0);
    busRead(A_CAUSE, v); check("R8 write zero clears", v, 32'h0);

    busWrite(A_CFG, 32'h3F);
    startWord("R10 busy ignore", 1'b1, 15, 16'h5AC3, 16'h0F0F);
    busRead(A_CTRL, v); check("R10 busy bit", v, 32'h3);
    busWrite(A_TX, 32'h0000_FFFF);
    busRead(A_TX, v); check("R10 tx unchanged", v, 32'h5AC3);
    finishWord("R10 busy ignore", 1'b1);

    busWrite(A_CTRL, 32'h0);
    #1 check("R2 csN high", {31'h0, spiCsN}, 32'h1);

    wait (obsQ.size() == 0);
    #1;
    finishRun();
  end
endmodule